// File: doc/BRIEF.md
# Open-Page DRAM Command Picker

This block sits in a memory controller for one DRAM rank and decides, every clock cycle, which single command goes to the device. Each bank owns a short in-order queue of pending commands (activate, read, write), filled through a push port. A bank timing tracker outside the block supplies, per bank, whether a row is open, which row, and whether the activate, read, write and precharge windows have elapsed. A separate limiter supplies one flag saying a further activate fits in the rolling activate window.

Selection follows a fixed priority. A pending refresh comes first: open banks are drained of hits to their open row or closed, and the refresh goes out once every bank is idle and rested. Otherwise a round-robin pass over the banks takes the first issuable entry of a queue, skipping entries that would overtake an older column access to the same row. A column access that directly follows its activate takes that activate out of the queue with it and counts as one row hit. If nothing is issuable, a second round-robin pass closes an open row that no queued command wants, or one that has reached the row-hit cap.

The decision is combinational on the registered queues and the current tracker inputs. The queues, counters and pointers update at the clock edge.

Top module: `dram_cmd_picker`

## Requirements
- R1: After reset no command is issued, both round-robin pointers point at bank 0, every row-hit counter is zero, no refresh is pending, and all queues are empty.
- R2: Issue codes on `iss_op` are 0 none, 1 activate, 2 read, 3 write, 4 precharge and 5 refresh, and pushes use codes 1 to 3. An activate is issuable when its bank is closed, `act_ok` of that bank is set and `faw_ok` is set. A read or write is issuable when its bank is open with `open_row` equal to the entry row, the matching `rd_ok`/`wr_ok` is set, and the bank's row-hit counter is below `acc_limit`. Bit i of `iss_rm` marks queue position i (0 is the head) of bank `iss_bank` as removed.
- R3: Normal scheduling visits banks round-robin starting at the main pointer and scans each queue from its head. After a normal issue the pointer moves to the bank after the issuing bank, wrapping at the last bank.
- R4: An issuable entry is skipped when an older entry of the same queue, other than an activate, targets the same row.
- R5: When the chosen read or write sits directly behind an activate in its queue, both entries are removed and the bank's row-hit counter increments by one.
- R6: A read or write is never issued while its bank's row-hit counter equals `acc_limit`.
- R7: When nothing is issuable, a precharge pass starting at its own pointer closes the first open bank whose precharge window is met and that has no queued entry to its open row or whose counter equals `acc_limit`. Every precharge the block issues clears that bank's counter.
- R8: A `refresh_req` pulse makes a refresh pending from the next cycle. While it is pending, no activate is issued and normal and precharge passes are suppressed. Banks are checked in order: at the first open bank, the first queued entry to its open row is issued if it is a legal read or write. If there is no such read or write, the bank is precharged once its window is met. The refresh is issued only when no bank is open and every `act_ok` is set, and issuing it clears the pending state.
- R9: With `posted_cas` set, an activate issued by the normal pass leaves the main pointer on its bank so that the same bank is visited first next cycle.
- R10: A push to a queue that holds the configured depth after this cycle's removals raises `push_err` in the same cycle, and the entry is dropped.
- R11: When no pass finds a command, `iss_valid` is low and queue contents stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Push one entry this cycle |
| push_bank | input | BW | Target bank queue of the push |
| push_op | input | 3 | Command code of the pushed entry (1 to 3) |
| push_row | input | ROW_W | Row of the pushed entry |
| push_err | output | 1 | Push hit a full queue and was dropped |
| bank_open | input | NB | Per bank: a row is open |
| open_row | input | NB x ROW_W | Per bank: the open row |
| act_ok | input | NB | Per bank: activate/refresh rest time reached |
| rd_ok | input | NB | Per bank: read window met |
| wr_ok | input | NB | Per bank: write window met |
| pre_ok | input | NB | Per bank: precharge window met |
| faw_ok | input | 1 | Another activate fits in the activate window |
| refresh_req | input | 1 | Pulse: a refresh is requested |
| posted_cas | input | 1 | Additive latency in use |
| acc_limit | input | ACC_W | Row-hit cap per open row |
| iss_valid | output | 1 | A command is issued this cycle |
| iss_op | output | 3 | Issued command code |
| iss_bank | output | BW | Bank of the issued command |
| iss_row | output | ROW_W | Row of the issued command |
| iss_rm | output | QD | Queue positions removed from bank `iss_bank` |

## Verification
The bench builds the block with four banks, queues of depth four, 8-bit rows and a 4-bit counter. Four banks are enough to show the main pointer wrapping from the last bank back to bank 0 and the posted-CAS hold standing against a competing bank. A depth of four lets the fifth push to one bank reach the overflow error and confirm the entry is dropped. Because the cap is a port, setting it to one brings the limit within two accesses, so a capped row, its forced precharge and the counter reset after it can be followed one cycle at a time.

// File: rtl/dcp_pkg.sv
// Shared command codes for the open-page command picker.
// Assumes a 3-bit command field on every port that carries one.
package dcp_pkg;
    localparam logic [2:0] OP_NONE = 3'd0;
    localparam logic [2:0] OP_ACT  = 3'd1;
    localparam logic [2:0] OP_RD   = 3'd2;
    localparam logic [2:0] OP_WR   = 3'd3;
    localparam logic [2:0] OP_PRE  = 3'd4;
    localparam logic [2:0] OP_REF  = 3'd5;

    localparam logic [1:0] SRC_REF  = 2'd0;
    localparam logic [1:0] SRC_NORM = 2'd1;
    localparam logic [1:0] SRC_PRE  = 2'd2;
endpackage

// File: rtl/dcp_bank_queue.sv
// One bank's in-order command queue. Removes any set of marked positions
// and compacts toward the head, then appends a push if room remains.
// Assumes rm only marks positions below the current count.
module dcp_bank_queue #(
    parameter int QD    = 4,
    parameter int ROW_W = 8,
    localparam int QW   = $clog2(QD + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_en,
    input  logic [2:0]                 push_op,
    input  logic [ROW_W-1:0]           push_row,
    input  logic [QD-1:0]              rm,
    output logic [QD-1:0][2:0]         q_op,
    output logic [QD-1:0][ROW_W-1:0]   q_row,
    output logic [QW-1:0]              q_cnt,
    output logic                       err
);
    logic [QD-1:0][2:0]       n_op;
    logic [QD-1:0][ROW_W-1:0] n_row;
    logic [QW-1:0]            n_cnt;

    // Next queue image: keep unmarked entries in order, then append.
    always_comb begin
        int k;
        k     = 0;
        n_op  = '0;
        n_row = '0;
        for (int i = 0; i < QD; i++) begin
            if (QW'(i) < q_cnt && !rm[i]) begin
                n_op[k]  = q_op[i];
                n_row[k] = q_row[i];
                k++;
            end
        end
        err   = push_en && (k == QD);
        n_cnt = QW'(k);
        if (push_en && k < QD) begin
            n_op[k]  = push_op;
            n_row[k] = push_row;
            n_cnt    = QW'(k + 1);
        end
    end

    // Queue storage register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_op  <= '0;
            q_row <= '0;
            q_cnt <= '0;
        end else begin
            q_op  <= n_op;
            q_row <= n_row;
            q_cnt <= n_cnt;
        end
    end
endmodule

// File: rtl/dcp_select.sv
// Combinational selection: refresh path, then normal round-robin pass,
// then precharge round-robin pass. Reports the chosen command, the queue
// positions it removes, and whether a row hit is counted.
// Assumes NB >= 2 and bank-state inputs valid this cycle.
module dcp_select
    import dcp_pkg::*;
#(
    parameter int NB    = 4,
    parameter int QD    = 4,
    parameter int ROW_W = 8,
    parameter int ACC_W = 4,
    localparam int QW   = $clog2(QD + 1),
    localparam int BW   = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic [NB-1:0][QD-1:0][2:0]       q_op,
    input  logic [NB-1:0][QD-1:0][ROW_W-1:0] q_row,
    input  logic [NB-1:0][QW-1:0]            q_cnt,
    input  logic [NB-1:0]                    bank_open,
    input  logic [NB-1:0][ROW_W-1:0]         open_row,
    input  logic [NB-1:0]                    act_ok,
    input  logic [NB-1:0]                    rd_ok,
    input  logic [NB-1:0]                    wr_ok,
    input  logic [NB-1:0]                    pre_ok,
    input  logic                             faw_ok,
    input  logic                             ref_pend,
    input  logic [NB-1:0][ACC_W-1:0]         acc_cnt,
    input  logic [ACC_W-1:0]                 acc_limit,
    input  logic [BW-1:0]                    rr_ptr,
    input  logic [BW-1:0]                    pre_ptr,
    output logic                             sel_valid,
    output logic [2:0]                       sel_op,
    output logic [BW-1:0]                    sel_bank,
    output logic [ROW_W-1:0]                 sel_row,
    output logic [QD-1:0]                    sel_rm,
    output logic                             sel_inc,
    output logic [1:0]                       sel_src
);
    // Legality of one queue entry against its bank's state.
    function automatic logic can_go(input logic [2:0] op, input logic [ROW_W-1:0] row,
                                    input logic open, input logic [ROW_W-1:0] orow,
                                    input logic aok, input logic rok, input logic wok,
                                    input logic faw, input logic under);
        case (op)
            OP_ACT:  can_go = !open && aok && faw;
            OP_RD:   can_go = open && row == orow && rok && under;
            OP_WR:   can_go = open && row == orow && wok && under;
            default: can_go = 1'b0;
        endcase
    endfunction

    // Priority search over the three passes.
    always_comb begin
        logic stop, hit, close, found, dep;
        int   sb, si, bi;
        sel_valid = 1'b0; sel_op = OP_NONE; sel_bank = '0; sel_row = '0;
        sel_rm = '0; sel_inc = 1'b0; sel_src = SRC_NORM;
        stop = 1'b0; hit = 1'b0; close = 1'b0; found = 1'b0; dep = 1'b0;
        sb = 0; si = 0; bi = 0;
        if (ref_pend) begin
            for (int b = 0; b < NB; b++) begin
                if (!stop) begin
                    if (bank_open[b]) begin
                        stop = 1'b1; hit = 1'b0; close = 1'b1;
                        for (int i = 0; i < QD; i++) begin
                            if (!hit && QW'(i) < q_cnt[b] && q_row[b][i] == open_row[b]) begin
                                hit = 1'b1;
                                if (q_op[b][i] != OP_ACT) begin
                                    close = 1'b0;
                                    if (can_go(q_op[b][i], q_row[b][i], bank_open[b], open_row[b],
                                               act_ok[b], rd_ok[b], wr_ok[b], faw_ok,
                                               acc_cnt[b] < acc_limit)) begin
                                        sel_valid = 1'b1; sel_op = q_op[b][i];
                                        sel_bank = BW'(b); sel_row = q_row[b][i];
                                        sel_rm[i] = 1'b1;
                                    end
                                end
                            end
                        end
                        if (close && pre_ok[b]) begin
                            sel_valid = 1'b1; sel_op = OP_PRE;
                            sel_bank = BW'(b); sel_row = open_row[b];
                        end
                    end else if (!act_ok[b]) begin
                        stop = 1'b1;
                    end
                end
            end
            if (!stop) begin
                sel_valid = 1'b1; sel_op = OP_REF;
            end
            sel_src = SRC_REF;
        end else begin
            for (int k = 0; k < NB; k++) begin
                bi = int'(rr_ptr) + k;
                if (bi >= NB) bi = bi - NB;
                for (int i = 0; i < QD; i++) begin
                    if (!found && QW'(i) < q_cnt[bi] &&
                        can_go(q_op[bi][i], q_row[bi][i], bank_open[bi], open_row[bi],
                               act_ok[bi], rd_ok[bi], wr_ok[bi], faw_ok,
                               acc_cnt[bi] < acc_limit)) begin
                        dep = 1'b0;
                        for (int j = 0; j < QD; j++) begin
                            if (j < i && q_op[bi][j] != OP_ACT && q_row[bi][j] == q_row[bi][i])
                                dep = 1'b1;
                        end
                        if (!dep) begin
                            found = 1'b1; sb = bi; si = i;
                        end
                    end
                end
            end
            if (found) begin
                sel_valid = 1'b1; sel_op = q_op[sb][si];
                sel_bank = BW'(sb); sel_row = q_row[sb][si];
                sel_rm[si] = 1'b1;
                if (si > 0 && (q_op[sb][si] == OP_RD || q_op[sb][si] == OP_WR)) begin
                    if (q_op[sb][si-1] == OP_ACT) begin
                        sel_rm[si-1] = 1'b1;
                        sel_inc = 1'b1;
                    end
                end
            end else begin
                for (int k = 0; k < NB; k++) begin
                    bi = int'(pre_ptr) + k;
                    if (bi >= NB) bi = bi - NB;
                    if (!found && bank_open[bi] && pre_ok[bi]) begin
                        hit = 1'b0;
                        for (int i = 0; i < QD; i++) begin
                            if (QW'(i) < q_cnt[bi] && q_row[bi][i] == open_row[bi]) hit = 1'b1;
                        end
                        if (!hit || acc_cnt[bi] == acc_limit) begin
                            found = 1'b1;
                            sel_valid = 1'b1; sel_op = OP_PRE;
                            sel_bank = BW'(bi); sel_row = open_row[bi];
                            sel_src = SRC_PRE;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/dram_cmd_picker.sv
// Top of the open-page command picker for one rank. Holds per-bank queues,
// row-hit counters, the refresh-pending flag and both round-robin pointers.
// Assumes the external tracker updates bank state from the issued command.
module dram_cmd_picker
    import dcp_pkg::*;
#(
    parameter int NB    = 4,
    parameter int QD    = 4,
    parameter int ROW_W = 8,
    parameter int ACC_W = 4,
    localparam int QW   = $clog2(QD + 1),
    localparam int BW   = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push_valid,
    input  logic [BW-1:0]             push_bank,
    input  logic [2:0]                push_op,
    input  logic [ROW_W-1:0]          push_row,
    output logic                      push_err,
    input  logic [NB-1:0]             bank_open,
    input  logic [NB-1:0][ROW_W-1:0]  open_row,
    input  logic [NB-1:0]             act_ok,
    input  logic [NB-1:0]             rd_ok,
    input  logic [NB-1:0]             wr_ok,
    input  logic [NB-1:0]             pre_ok,
    input  logic                      faw_ok,
    input  logic                      refresh_req,
    input  logic                      posted_cas,
    input  logic [ACC_W-1:0]          acc_limit,
    output logic                      iss_valid,
    output logic [2:0]                iss_op,
    output logic [BW-1:0]             iss_bank,
    output logic [ROW_W-1:0]          iss_row,
    output logic [QD-1:0]             iss_rm
);
    logic [NB-1:0][QD-1:0][2:0]       q_op;
    logic [NB-1:0][QD-1:0][ROW_W-1:0] q_row;
    logic [NB-1:0][QW-1:0]            q_cnt;
    logic [NB-1:0]                    q_err;
    logic [NB-1:0][ACC_W-1:0]         acc_cnt;
    logic [BW-1:0]                    rr_ptr, pre_ptr;
    logic                             ref_pend;
    logic                             sel_inc;
    logic [1:0]                       sel_src;

    for (genvar b = 0; b < NB; b++) begin : g_bank
        dcp_bank_queue #(.QD(QD), .ROW_W(ROW_W)) u_q (
            .clk      (clk),
            .rst_n    (rst_n),
            .push_en  (push_valid && push_bank == BW'(b)),
            .push_op  (push_op),
            .push_row (push_row),
            .rm       ((iss_valid && iss_bank == BW'(b)) ? iss_rm : '0),
            .q_op     (q_op[b]),
            .q_row    (q_row[b]),
            .q_cnt    (q_cnt[b]),
            .err      (q_err[b])
        );
    end

    assign push_err = |q_err;

    dcp_select #(.NB(NB), .QD(QD), .ROW_W(ROW_W), .ACC_W(ACC_W)) u_sel (
        .q_op      (q_op),
        .q_row     (q_row),
        .q_cnt     (q_cnt),
        .bank_open (bank_open),
        .open_row  (open_row),
        .act_ok    (act_ok),
        .rd_ok     (rd_ok),
        .wr_ok     (wr_ok),
        .pre_ok    (pre_ok),
        .faw_ok    (faw_ok),
        .ref_pend  (ref_pend),
        .acc_cnt   (acc_cnt),
        .acc_limit (acc_limit),
        .rr_ptr    (rr_ptr),
        .pre_ptr   (pre_ptr),
        .sel_valid (iss_valid),
        .sel_op    (iss_op),
        .sel_bank  (iss_bank),
        .sel_row   (iss_row),
        .sel_rm    (iss_rm),
        .sel_inc   (sel_inc),
        .sel_src   (sel_src)
    );

    // Step a bank index by one with wrap.
    function automatic logic [BW-1:0] nxt(input logic [BW-1:0] x);
        nxt = (int'(x) == NB - 1) ? '0 : x + 1'b1;
    endfunction

    // Pointers and refresh-pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr   <= '0;
            pre_ptr  <= '0;
            ref_pend <= 1'b0;
        end else begin
            ref_pend <= (ref_pend && !(iss_valid && iss_op == OP_REF)) || refresh_req;
            if (iss_valid) begin
                if (sel_src == SRC_NORM)
                    rr_ptr <= (posted_cas && iss_op == OP_ACT) ? iss_bank : nxt(iss_bank);
                else
                    rr_ptr <= nxt(rr_ptr);
                if (sel_src == SRC_PRE) pre_ptr <= iss_bank;
            end
        end
    end

    // Row-hit counters: clear on precharge, count paired column accesses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_cnt <= '0;
        end else if (iss_valid) begin
            if (iss_op == OP_PRE)  acc_cnt[iss_bank] <= '0;
            else if (sel_inc)      acc_cnt[iss_bank] <= acc_cnt[iss_bank] + 1'b1;
        end
    end
endmodule

// File: rtl/dcp_chk.sv
// Protocol checks for the command picker, bound to every instance.
// Assumes it sees the top's internal counters and refresh flag.
module dcp_chk
    import dcp_pkg::*;
#(
    parameter int NB    = 4,
    parameter int ROW_W = 8,
    parameter int ACC_W = 4,
    localparam int BW   = (NB > 1) ? $clog2(NB) : 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     push_valid,
    input logic                     push_err,
    input logic [NB-1:0]            bank_open,
    input logic [NB-1:0][ROW_W-1:0] open_row,
    input logic [NB-1:0]            act_ok,
    input logic                     refresh_req,
    input logic [ACC_W-1:0]         acc_limit,
    input logic                     ref_pend,
    input logic [NB-1:0][ACC_W-1:0] acc_cnt,
    input logic                     iss_valid,
    input logic [2:0]               iss_op,
    input logic [BW-1:0]            iss_bank,
    input logic [ROW_W-1:0]         iss_row
);
    a_r8_ref_all_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_op == OP_REF) |-> (bank_open == '0 && &act_ok));
    a_r8_no_act_in_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_pend && iss_valid) |-> iss_op != OP_ACT);
    a_r8_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_op == OP_REF && !refresh_req) |=> !ref_pend);
    a_r2_col_row_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && (iss_op == OP_RD || iss_op == OP_WR)) |->
        (bank_open[iss_bank] && open_row[iss_bank] == iss_row));
    a_r6_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && (iss_op == OP_RD || iss_op == OP_WR)) |-> acc_cnt[iss_bank] < acc_limit);
    a_r7_pre_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_op == OP_PRE) |=> acc_cnt[$past(iss_bank)] == '0);
    a_r10_err_needs_push: assert property (@(posedge clk) disable iff (!rst_n)
        push_err |-> push_valid);
endmodule

bind dram_cmd_picker dcp_chk #(.NB(NB), .ROW_W(ROW_W), .ACC_W(ACC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_err(push_err),
    .bank_open(bank_open), .open_row(open_row), .act_ok(act_ok),
    .refresh_req(refresh_req), .acc_limit(acc_limit), .ref_pend(ref_pend),
    .acc_cnt(acc_cnt), .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_bank(iss_bank), .iss_row(iss_row)
);

// File: tb/tb_dram_cmd_picker.sv
// Self-checking bench: table of single-entry issues, then directed scenarios.
module tb_dram_cmd_picker;
    localparam int NB = 4, QD = 4, ROW_W = 8, ACC_W = 4, BW = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic push_valid = 1'b0; logic [BW-1:0] push_bank = '0;
    logic [2:0] push_op = '0; logic [ROW_W-1:0] push_row = '0;
    logic push_err;
    logic [NB-1:0] bank_open, act_ok, rd_ok, wr_ok, pre_ok;
    logic [NB-1:0][ROW_W-1:0] open_row;
    logic faw_ok, refresh_req = 1'b0, posted_cas = 1'b0;
    logic [ACC_W-1:0] acc_limit = 4'd15;
    logic iss_valid; logic [2:0] iss_op; logic [BW-1:0] iss_bank;
    logic [ROW_W-1:0] iss_row; logic [QD-1:0] iss_rm;
    int tests = 0, fails = 0;

    always #2.5 clk = ~clk;

    dram_cmd_picker #(.NB(NB), .QD(QD), .ROW_W(ROW_W), .ACC_W(ACC_W)) dut (.*);

    // Bank/op/row per row: {bank nibble, op nibble, row byte}; reads/writes hit an open row.
    localparam logic [15:0] TBL [8] = '{16'h0101, 16'h1102, 16'h2203, 16'h3304,
                                        16'h12AA, 16'h0355, 16'h31FF, 16'h2100};

    task automatic tick(); @(posedge clk); #1; endtask
    task automatic settle(); #1; endtask

    task automatic quiet();
        bank_open = '0; open_row = '0; act_ok = '1; rd_ok = '0; wr_ok = '0;
        pre_ok = '0; faw_ok = 1'b0;
    endtask

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic chk_iss(string tag, logic v, logic [2:0] op, logic [BW-1:0] b,
                           logic [ROW_W-1:0] row, logic [QD-1:0] rm);
        chk(tag, {17'd0, iss_valid, iss_op, iss_bank, iss_row, iss_rm},
                 {17'd0, v, op, b, row, rm});
    endtask

    task automatic push(logic [BW-1:0] b, logic [2:0] op, logic [ROW_W-1:0] row);
        push_valid = 1'b1; push_bank = b; push_op = op; push_row = row;
        tick();
        push_valid = 1'b0;
    endtask

    task automatic do_reset();
        quiet(); posted_cas = 1'b0; acc_limit = 4'd15;
        rst_n = 1'b0; tick(); tick(); rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        do_reset();
        settle();
        chk_iss("R1 reset idle", 0, 0, 0, 0, 0);
        chk("R1 reset no error", {31'd0, push_err}, 0);

        // R2/R3 table: single entries that issue at the head.
        for (int t = 0; t < 8; t++) begin
            logic [BW-1:0] b; logic [2:0] op; logic [ROW_W-1:0] r;
            b = TBL[t][13:12]; op = TBL[t][10:8]; r = TBL[t][7:0];
            quiet();
            if (op == 3'd1) faw_ok = 1'b1;
            else begin bank_open[b] = 1'b1; open_row[b] = r; rd_ok = '1; wr_ok = '1; end
            push(b, op, r);
            settle();
            chk_iss("R2 table issue", 1, op, b, r, 4'b0001);
            tick(); quiet();
        end

        // R5/R6/R7: pairing, cap, forced precharge, counter reset.
        do_reset();
        acc_limit = 4'd1;
        push(0, 3'd1, 8'd5); push(0, 3'd2, 8'd5);
        bank_open[0] = 1'b1; open_row[0] = 8'd5; rd_ok[0] = 1'b1;
        settle();
        chk_iss("R5 paired read removes activate", 1, 3'd2, 0, 8'd5, 4'b0011);
        tick();
        push(0, 3'd2, 8'd5);
        settle();
        chk_iss("R6 capped read held", 0, 0, 0, 0, 0);
        pre_ok[0] = 1'b1; settle();
        chk_iss("R7 precharge at cap", 1, 3'd4, 0, 8'd5, 4'b0000);
        tick(); settle();
        chk_iss("R7 counter cleared, read issues", 1, 3'd2, 0, 8'd5, 4'b0001);
        tick(); quiet();

        // R4/R11: dependency skip and idle cycle.
        do_reset();
        bank_open[1] = 1'b1; open_row[1] = 8'd7; rd_ok[1] = 1'b1;
        push(1, 3'd3, 8'd7); push(1, 3'd2, 8'd7);
        pre_ok[1] = 1'b1; settle();
        chk_iss("R4 read behind blocked write skipped", 0, 0, 0, 0, 0);
        tick(); settle();
        chk_iss("R11 nothing issued, still idle", 0, 0, 0, 0, 0);
        wr_ok[1] = 1'b1; settle();
        chk_iss("R4 older write first", 1, 3'd3, 1, 8'd7, 4'b0001);
        tick(); settle();
        chk_iss("R11 queue kept read", 1, 3'd2, 1, 8'd7, 4'b0001);
        tick(); quiet();

        // R3: round-robin order with wrap.
        do_reset();
        push(2, 3'd1, 8'd20); push(1, 3'd1, 8'd21);
        faw_ok = 1'b1; settle();
        chk_iss("R3 pointer 0 picks bank 1", 1, 3'd1, 1, 8'd21, 4'b0001);
        tick(); settle();
        chk_iss("R3 then bank 2", 1, 3'd1, 2, 8'd20, 4'b0001);
        tick(); faw_ok = 1'b0;
        push(0, 3'd1, 8'd22); push(3, 3'd1, 8'd23);
        faw_ok = 1'b1; settle();
        chk_iss("R3 pointer 3 picks bank 3", 1, 3'd1, 3, 8'd23, 4'b0001);
        tick(); settle();
        chk_iss("R3 wrap to bank 0", 1, 3'd1, 0, 8'd22, 4'b0001);
        tick(); quiet();

        // R9: posted-CAS pointer hold.
        do_reset();
        posted_cas = 1'b1;
        push(1, 3'd1, 8'd3); push(1, 3'd2, 8'd3); push(2, 3'd1, 8'd4);
        faw_ok = 1'b1; settle();
        chk_iss("R9 activate bank 1", 1, 3'd1, 1, 8'd3, 4'b0001);
        tick();
        bank_open[1] = 1'b1; open_row[1] = 8'd3; rd_ok[1] = 1'b1; settle();
        chk_iss("R9 read on same bank before bank 2", 1, 3'd2, 1, 8'd3, 4'b0001);
        tick(); settle();
        chk_iss("R9 then bank 2 activate", 1, 3'd1, 2, 8'd4, 4'b0001);
        tick(); quiet(); posted_cas = 1'b0;

        // R8: refresh drain, close, wait, refresh, resume.
        do_reset();
        bank_open[0] = 1'b1; open_row[0] = 8'd9;
        push(0, 3'd2, 8'd9); push(2, 3'd1, 8'd30);
        refresh_req = 1'b1; tick(); refresh_req = 1'b0;
        faw_ok = 1'b1; pre_ok[0] = 1'b1; settle();
        chk_iss("R8 normal pass suppressed", 0, 0, 0, 0, 0);
        tick();
        rd_ok[0] = 1'b1; settle();
        chk_iss("R8 drain open-row read", 1, 3'd2, 0, 8'd9, 4'b0001);
        tick(); settle();
        chk_iss("R8 close open bank", 1, 3'd4, 0, 8'd9, 4'b0000);
        tick();
        bank_open[0] = 1'b0; act_ok[0] = 1'b0; settle();
        chk_iss("R8 wait for rest time", 0, 0, 0, 0, 0);
        act_ok = '1; settle();
        chk_iss("R8 refresh issued", 1, 3'd5, 0, 8'd0, 4'b0000);
        tick(); settle();
        chk_iss("R8 pending cleared, activate resumes", 1, 3'd1, 2, 8'd30, 4'b0001);
        tick(); quiet();

        // R10: overflow error and dropped entry.
        do_reset();
        for (int n = 0; n < 4; n++) begin
            push_valid = 1'b1; push_bank = 2'd3; push_op = 3'd1; push_row = 8'(10 + n);
            settle();
            chk("R10 no error below depth", {31'd0, push_err}, 0);
            tick();
        end
        push_valid = 1'b1; push_row = 8'd14; settle();
        chk("R10 error at depth", {31'd0, push_err}, 1);
        tick(); push_valid = 1'b0;
        faw_ok = 1'b1;
        for (int n = 0; n < 4; n++) begin
            settle();
            chk_iss("R10 stored entries in order", 1, 3'd1, 3, 8'(10 + n), 4'b0001);
            tick();
        end
        settle();
        chk_iss("R10 overflow entry dropped", 0, 0, 0, 0, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule